// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Unit

This unit holds a small bank of hardware lock flags that two independent agents, a left port and a right port, use to coordinate access to a shared resource. Each port has a select strobe for the flag space, its own write and read enables, and a flag index. A port asks for a flag by writing a 0 to it. It then reads the same flag back to see whether it now holds it. A flag is held by at most one port at any time.

When both ports ask for the same free flag in the same clock cycle, the left port gets it. A request that cannot be granted stays pending. It is granted in the same cycle in which the holder gives the flag up. Only the holder can give a flag up. When the other port writes a 1 to the flag, it only withdraws its own pending request.

The unit is synchronous, with one clock and an active-high synchronous reset. Read data is registered and appears one cycle after the read strobe.

Top module: `dpsem_unit`

## Requirements
- R1: After reset all eight flags are free, and a read of any flag from either port returns 1.
- R2: The 3-bit address picks one of eight independent flags. Claiming or releasing one flag leaves the other flags unchanged.
- R3: A write with data 0 to a free flag grants it to the writer. A read-back returns 0 to the holder and 1 to the other port, in the cycle after the read strobe.
- R4: If both ports write 0 to the same free flag in the same cycle, the left port is granted the flag.
- R5: A request from a port that is not the holder stays pending. It is granted on the clock edge at which the holder writes 1 to that flag.
- R6: A write of 1 from the port that does not hold the flag leaves the holder unchanged. It withdraws that port's own pending request, so a later release by the holder leaves the flag free.
- R7: When the holder writes 1 and no request from the other port is pending, the flag becomes free and both ports read 1.
- R8: A write with the port's select low has no effect on any flag.
- R9: A read strobe is select high, write enable low and read enable high. In the cycle after any cycle without a read strobe, that port's read data is 1.
- R10: A flag held by one port is never taken away by a request from the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_l | input | 1 | Left flag-space select |
| we_l | input | 1 | Left write enable (1 = write) |
| oe_l | input | 1 | Left read enable |
| addr_l | input | 3 | Left flag index |
| wdata_l | input | 1 | Left write data (0 = request, 1 = release) |
| rdata_l | output | 1 | Left registered read data (0 = held by left) |
| sel_r | input | 1 | Right flag-space select |
| we_r | input | 1 | Right write enable (1 = write) |
| oe_r | input | 1 | Right read enable |
| addr_r | input | 3 | Right flag index |
| wdata_r | input | 1 | Right write data (0 = request, 1 = release) |
| rdata_r | output | 1 | Right registered read data (0 = held by right) |

## Verification
The tests drive single-port claims and releases, requests from both ports to the same flag in the same cycle, and claims from both ports to different flags in the same cycle. Each of these separates a correct tie-break from a wrong winner and independent flags from shared flags. Requests made while another port holds the flag, followed by a withdrawal or by a release, show whether a pending request is handed over, whether a withdrawn one is dropped, and whether the holder can be pre-empted. Writes with select low and reads with read enable low confirm that stray strobes change neither the stored flags nor the read data.

// File: rtl/dpsem_pkg.sv
package dpsem_pkg;
  typedef enum logic [1:0] {
    SEM_FREE  = 2'd0,
    SEM_LEFT  = 2'd1,
    SEM_RIGHT = 2'd2
  } sem_own_t;
endpackage

// File: rtl/dpsem_decode.sv
module dpsem_decode #(
  parameter int NUM_SEM = 8,
  localparam int ADDR_W = $clog2(NUM_SEM)
) (
  input  logic              sel,
  input  logic              we,
  input  logic              oe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wdata,
  output logic [NUM_SEM-1:0] req_vec,
  output logic [NUM_SEM-1:0] rel_vec,
  output logic              rd_stb
);
  for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
    logic hit;
    assign hit        = sel && we && (addr == ADDR_W'(g));
    assign req_vec[g] = hit && !wdata;
    assign rel_vec[g] = hit && wdata;
  end
  assign rd_stb = sel && !we && oe;
endmodule

// File: rtl/dpsem_cell.sv
module dpsem_cell
  import dpsem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_l,
  input  logic rel_l,
  input  logic req_r,
  input  logic rel_r,
  output logic own_l,
  output logic own_r
);
  sem_own_t owner_q, owner_d;
  logic want_l_q, want_r_q, want_l_d, want_r_d;

  always_comb begin
    want_l_d = req_l ? 1'b1 : (rel_l ? 1'b0 : want_l_q);
    want_r_d = req_r ? 1'b1 : (rel_r ? 1'b0 : want_r_q);
    unique case (owner_q)
      SEM_LEFT:  owner_d = want_l_d ? SEM_LEFT  : (want_r_d ? SEM_RIGHT : SEM_FREE);
      SEM_RIGHT: owner_d = want_r_d ? SEM_RIGHT : (want_l_d ? SEM_LEFT  : SEM_FREE);
      default:   owner_d = want_l_d ? SEM_LEFT  : (want_r_d ? SEM_RIGHT : SEM_FREE);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q  <= SEM_FREE;
      want_l_q <= 1'b0;
      want_r_q <= 1'b0;
    end else begin
      owner_q  <= owner_d;
      want_l_q <= want_l_d;
      want_r_q <= want_r_d;
    end
  end

  assign own_l = (owner_q == SEM_LEFT);
  assign own_r = (owner_q == SEM_RIGHT);

  AST_TIE_LEFT: assert property (@(posedge clk) disable iff (rst)
    (!own_l && !own_r && !want_l_q && !want_r_q && req_l && req_r) |=> own_l); // R4
  AST_HANDOVER: assert property (@(posedge clk) disable iff (rst)
    (own_l && rel_l && (want_r_q || req_r) && !rel_r) |=> own_r); // R5
  AST_NO_PREEMPT_L: assert property (@(posedge clk) disable iff (rst)
    (own_l && !rel_l) |=> own_l); // R10
  AST_NO_PREEMPT_R: assert property (@(posedge clk) disable iff (rst)
    (own_r && !rel_r) |=> own_r); // R10
  AST_CLAIM_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (!own_l && !own_r && !want_l_q && !req_l && req_r) |=> own_r); // R3
  AST_FREE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!own_l && !own_r && !want_l_q && !want_r_q && !req_l && !req_r) |=> (!own_l && !own_r)); // R8
endmodule

// File: rtl/dpsem_rdport.sv
module dpsem_rdport #(
  parameter int NUM_SEM = 8,
  localparam int ADDR_W = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_stb,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SEM-1:0] owned,
  output logic               rdata
);
  always_ff @(posedge clk) begin
    if (rst)         rdata <= 1'b1;
    else if (rd_stb) rdata <= !owned[addr];
    else             rdata <= 1'b1;
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> rdata); // R9
  AST_READ_OWNED: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && owned[addr]) |=> !rdata); // R3
endmodule

// File: rtl/dpsem_unit.sv
module dpsem_unit #(
  parameter int NUM_SEM = 8,
  localparam int ADDR_W = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_l,
  input  logic              we_l,
  input  logic              oe_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic              wdata_l,
  output logic              rdata_l,
  input  logic              sel_r,
  input  logic              we_r,
  input  logic              oe_r,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic              wdata_r,
  output logic              rdata_r
);
  logic [NUM_SEM-1:0] req_l, rel_l, req_r, rel_r, own_l, own_r;
  logic rd_l, rd_r;

  dpsem_decode #(.NUM_SEM(NUM_SEM)) i_dec_l (
    .sel(sel_l), .we(we_l), .oe(oe_l), .addr(addr_l), .wdata(wdata_l),
    .req_vec(req_l), .rel_vec(rel_l), .rd_stb(rd_l));
  dpsem_decode #(.NUM_SEM(NUM_SEM)) i_dec_r (
    .sel(sel_r), .we(we_r), .oe(oe_r), .addr(addr_r), .wdata(wdata_r),
    .req_vec(req_r), .rel_vec(rel_r), .rd_stb(rd_r));

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
    dpsem_cell i_cell (
      .clk(clk), .rst(rst),
      .req_l(req_l[g]), .rel_l(rel_l[g]),
      .req_r(req_r[g]), .rel_r(rel_r[g]),
      .own_l(own_l[g]), .own_r(own_r[g]));
  end

  dpsem_rdport #(.NUM_SEM(NUM_SEM)) i_rd_l (
    .clk(clk), .rst(rst), .rd_stb(rd_l), .addr(addr_l), .owned(own_l), .rdata(rdata_l));
  dpsem_rdport #(.NUM_SEM(NUM_SEM)) i_rd_r (
    .clk(clk), .rst(rst), .rd_stb(rd_r), .addr(addr_r), .owned(own_r), .rdata(rdata_r));

  AST_ONE_HOLDER: assert property (@(posedge clk) disable iff (rst)
    (own_l & own_r) == '0); // R2
endmodule

// File: tb/test_dpsem_unit.sv
`timescale 1ns/1ps
module test_dpsem_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_l = 0, we_l = 0, oe_l = 0, wdata_l = 0;
  logic sel_r = 0, we_r = 0, oe_r = 0, wdata_r = 0;
  logic [2:0] addr_l = 0, addr_r = 0;
  logic rdata_l, rdata_r;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dpsem_unit i_dpsem_unit (
    .clk(clk), .rst(rst),
    .sel_l(sel_l), .we_l(we_l), .oe_l(oe_l), .addr_l(addr_l), .wdata_l(wdata_l), .rdata_l(rdata_l),
    .sel_r(sel_r), .we_r(we_r), .oe_r(oe_r), .addr_r(addr_r), .wdata_r(wdata_r), .rdata_r(rdata_r));

  task automatic check(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    sel_l = 0; we_l = 0; oe_l = 0; wdata_l = 0;
    sel_r = 0; we_r = 0; oe_r = 0; wdata_r = 0;
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(bit right, logic [2:0] a, logic v, logic s = 1'b1);
    if (right) begin sel_r = s; we_r = 1; addr_r = a; wdata_r = v; end
    else       begin sel_l = s; we_l = 1; addr_l = a; wdata_l = v; end
    cyc(); idle();
  endtask

  task automatic wr2(logic [2:0] al, logic vl, logic [2:0] ar, logic vr);
    sel_l = 1; we_l = 1; addr_l = al; wdata_l = vl;
    sel_r = 1; we_r = 1; addr_r = ar; wdata_r = vr;
    cyc(); idle();
  endtask

  task automatic rd(logic [2:0] a, string req, logic el, logic er);
    sel_l = 1; oe_l = 1; addr_l = a;
    sel_r = 1; oe_r = 1; addr_r = a;
    cyc(); idle();
    check({req, " left"}, rdata_l, el);
    check({req, " right"}, rdata_r, er);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) rd(3'(i), "R1", 1'b1, 1'b1);
  endtask

  task automatic t_claim();
    wr(0, 3'd3, 1'b0);
    rd(3'd3, "R3", 1'b0, 1'b1);
    rd(3'd2, "R2", 1'b1, 1'b1);
    rd(3'd4, "R2", 1'b1, 1'b1);
    wr(0, 3'd3, 1'b1);
    rd(3'd3, "R7", 1'b1, 1'b1);
    wr(1, 3'd6, 1'b0);
    rd(3'd6, "R3", 1'b1, 1'b0);
    wr(1, 3'd6, 1'b1);
  endtask

  task automatic t_tie();
    wr2(3'd5, 1'b0, 3'd5, 1'b0);
    rd(3'd5, "R4", 1'b0, 1'b1);
    wr(0, 3'd5, 1'b1);
    rd(3'd5, "R5", 1'b1, 1'b0);
    wr(1, 3'd5, 1'b1);
    rd(3'd5, "R7", 1'b1, 1'b1);
  endtask

  task automatic t_nonowner();
    wr(1, 3'd1, 1'b0);
    wr(0, 3'd1, 1'b0);
    rd(3'd1, "R10", 1'b1, 1'b0);
    wr(0, 3'd1, 1'b1);
    rd(3'd1, "R6", 1'b1, 1'b0);
    wr(1, 3'd1, 1'b1);
    rd(3'd1, "R6", 1'b1, 1'b1);
  endtask

  task automatic t_nosel();
    wr(0, 3'd6, 1'b0, 1'b0);
    rd(3'd6, "R8", 1'b1, 1'b1);
    wr(0, 3'd0, 1'b0);
    sel_l = 1; oe_l = 0; addr_l = 3'd0;
    cyc(); idle();
    check("R9 oe low", rdata_l, 1'b1);
    sel_l = 1; oe_l = 1; addr_l = 3'd0;
    cyc(); idle();
    check("R9 read", rdata_l, 1'b0);
    cyc();
    check("R9 idle", rdata_l, 1'b1);
    wr(0, 3'd0, 1'b1);
  endtask

  task automatic t_split();
    wr2(3'd2, 1'b0, 3'd7, 1'b0);
    rd(3'd2, "R2", 1'b0, 1'b1);
    rd(3'd7, "R2", 1'b1, 1'b0);
    wr2(3'd2, 1'b1, 3'd7, 1'b1);
    rd(3'd2, "R7", 1'b1, 1'b1);
    rd(3'd7, "R7", 1'b1, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset left", rdata_l, 1'b1);
    check("R1 reset right", rdata_r, 1'b1);
    t_reset();
    t_claim();
    t_tie();
    t_nonowner();
    t_nosel();
    t_split();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule